// File: doc/BRIEF.md
# Split-Capable Serial Access Register Controller

This block manages a 512-word by 8-bit serial access register that sits next to a DRAM row buffer. Row data enters the register through transfer events: a conventional read transfer copies a whole row into the register, and a conventional write transfer copies the register out as a row image for write-back. Split transfers move only the half of the register that the serial side is not using at that moment. A serial clock, sampled as a synchronous enable, moves one word per tick. In output mode the word at the serial pointer is presented. In input mode the serial input word is stored at the pointer.

The block holds the serial pointer, the port direction, the single/split mode and two stored half taps. It drives a half-select flag that shows which half of the register the pointer is in. In split mode the pointer does not wrap inside a half. After the last word of a half it jumps to the tap stored for the other half. This lets the serial side keep streaming while the other half is refilled or drained.

Row words move one per clock. For loads, the block drives `row_addr` with `row_rd`, and the surrounding logic must present that word on `row_in` in the same cycle. For unloads, the block drives `row_out`, `row_out_addr` and `row_out_we` together.

Top module: `serial_reg_ctrl`

## Requirements
- R1: After reset the pointer is 0, `ser_out_mode` is 1 (output), the register is in single mode, `half_flag` is 0, `xfer_ready` is 1 and `xfer_err` is 0.
- R2: A conventional read transfer (`xfer_kind` 2'b00) loads all 512 words and sets output mode. The first serial tick after it completes presents the word at the tap on `ser_dout`, and later ticks present ascending addresses, wrapping from 511 to 0.
- R3: A serial tick with `ser_en` low still advances the pointer. It leaves `ser_dout` unchanged and stores nothing.
- R4: A conventional write transfer (`xfer_kind` 2'b01) emits all 512 stored words on the row output and sets input mode (`ser_out_mode` 0). Serial ticks with `ser_en` high then store `ser_din` at ascending addresses from the tap.
- R5: Split transfers (`xfer_kind` 2'b10 load, 2'b11 unload) leave `ser_out_mode` unchanged.
- R6: `half_flag` is the top bit of the pointer: 0 for addresses 0-255 and 1 for 256-511. In split mode it toggles on the tick that consumes the last word of a half.
- R7: In split mode, the tick after address 255 or 511 moves the pointer to the tap stored for the other half. A stored tap is used only once.
- R8: A split transfer moves only the half opposite the pointer: 256 row words, with addresses inside that half. The top bit of `xfer_tap` is ignored, and the active half's contents are unchanged.
- R9: In split mode, if the other half has no unused stored tap, the pointer enters that half at its first address.
- R10: A split transfer requested before any conventional transfer is dropped. `xfer_err` pulses for one cycle, and no row word moves.
- R11: During a conventional transfer, serial ticks are ignored and `ser_dout` holds its previous word. The first tick after completion presents the new row's word at the tap.
- R12: While a transfer runs, `xfer_ready` is 0. Row reads (`row_rd`) and row outputs (`row_out_we`) are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_en | input | 1 | Serial tick, one word per cycle it is high |
| ser_en | input | 1 | Serial access enable; low suppresses data movement only |
| ser_din | input | 8 | Serial input word (input mode) |
| ser_dout | output | 8 | Serial output word, registered |
| ser_out_mode | output | 1 | 1 = output mode, 0 = input mode |
| half_flag | output | 1 | Half holding the pointer |
| xfer_req | input | 1 | Transfer request, taken when `xfer_ready` is high |
| xfer_kind | input | 2 | 00 read, 01 write, 10 split read, 11 split write |
| xfer_tap | input | 9 | Start tap carried by the transfer |
| xfer_ready | output | 1 | No transfer in progress |
| xfer_err | output | 1 | One-cycle pulse: split transfer refused |
| row_addr | output | 9 | Row word address being loaded |
| row_rd | output | 1 | `row_in` is taken at `row_addr` this cycle |
| row_in | input | 8 | Row word for `row_addr` |
| row_out | output | 8 | Register word being emitted |
| row_out_addr | output | 9 | Address of `row_out` |
| row_out_we | output | 1 | `row_out` is valid this cycle |

## Verification
A wrong pointer shows up on `ser_dout` at the next enabled serial tick. A wrong or stale stored tap stays hidden until the tick after a half boundary, which can be up to 256 ticks after the split transfer that caused it. A wrong direction bit or a missed serial store cannot be seen on the serial side. It appears only in the row image of the next write transfer, which is why the bench drains the register after serial writes. A split transfer that touched the wrong half appears as bad words either in the row-address range during the transfer or when the pointer later crosses into the corrupted half.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    XK_READ        = 2'b00,
    XK_WRITE       = 2'b01,
    XK_SPLIT_READ  = 2'b10,
    XK_SPLIT_WRITE = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } xfer_state_e;
endpackage

// File: rtl/sar_store.sv
module sar_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Dual-port storage: port A faces the row, port B faces the serial side.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_rdata <= mem[a_addr];
    if (b_we) mem[b_addr] <= b_wdata;
    if (b_re) b_rdata <= mem[b_addr];
  end

  // R8: row side and serial side never write the same word together
  a_r8_no_port_collision: assert property (@(posedge clk) disable iff (rst)
    (a_we && b_we) |-> (a_addr != b_addr));
endmodule

// File: rtl/sar_xfer.sv
module sar_xfer
  import sar_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] tap,
  input  logic              act_half,
  output logic              ready,
  output logic              err,
  output logic [ADDR_W-1:0] row_addr,
  output logic              row_rd,
  output logic [ADDR_W-1:0] row_out_addr,
  output logic              row_out_we,
  output logic [ADDR_W-1:0] a_addr,
  output logic              a_we,
  output logic              a_re,
  output logic              done,
  output logic [1:0]        done_kind,
  output logic [ADDR_W-1:0] done_tap,
  output logic              done_half,
  output logic              conv_busy
);
  localparam int HALF_W = ADDR_W - 1;

  xfer_state_e       state;
  xfer_kind_e        kind_q;
  logic [ADDR_W-1:0] tap_q;
  logic              half_q;
  logic [ADDR_W-1:0] cnt;
  logic              conv_seen;

  logic              is_split;
  logic              is_load;
  logic              last;
  logic [ADDR_W-1:0] cur_addr;

  assign is_split = kind_q[1];
  assign is_load  = ~kind_q[0];
  assign last     = is_split ? (&cnt[HALF_W-1:0]) : (&cnt);
  assign cur_addr = is_split ? {half_q, cnt[HALF_W-1:0]} : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      kind_q       <= XK_READ;
      tap_q        <= '0;
      half_q       <= 1'b0;
      cnt          <= '0;
      conv_seen    <= 1'b0;
      err          <= 1'b0;
      done         <= 1'b0;
      row_addr     <= '0;
      row_rd       <= 1'b0;
      row_out_addr <= '0;
      row_out_we   <= 1'b0;
    end else begin
      err        <= 1'b0;
      done       <= 1'b0;
      row_rd     <= 1'b0;
      row_out_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            if (kind[1] && !conv_seen) begin
              err <= 1'b1;
            end else begin
              kind_q <= xfer_kind_e'(kind);
              tap_q  <= tap;
              half_q <= ~act_half;
              cnt    <= '0;
              state  <= ST_RUN;
              if (!kind[1]) conv_seen <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (is_load) begin
            row_addr <= cur_addr;
            row_rd   <= 1'b1;
          end else begin
            row_out_addr <= cur_addr;
            row_out_we   <= 1'b1;
          end
          cnt <= cnt + 1'b1;
          if (last) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready     = (state == ST_IDLE);
  assign a_we      = row_rd;
  assign a_re      = (state == ST_RUN) && !is_load;
  assign a_addr    = row_rd ? row_addr : cur_addr;
  assign done_kind = kind_q;
  assign done_tap  = tap_q;
  assign done_half = half_q;
  assign conv_busy = ((state != ST_IDLE) || done) && !is_split;

  // R10: an early split request is refused and starts nothing
  a_r10_early_split_refused: assert property (@(posedge clk) disable iff (rst)
    (req && state == ST_IDLE && kind[1] && !conv_seen) |=> (err && state == ST_IDLE));

  // R12: row loads and row emits never overlap
  a_r12_one_row_direction: assert property (@(posedge clk) disable iff (rst)
    $onehot0({row_rd, row_out_we}));
endmodule

// File: rtl/sar_pointer.sv
module sar_pointer #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_en,
  input  logic              conv_busy,
  input  logic              done,
  input  logic [1:0]        done_kind,
  input  logic [ADDR_W-1:0] done_tap,
  input  logic              done_half,
  output logic [ADDR_W-1:0] ptr,
  output logic              step,
  output logic              flag,
  output logic              out_mode
);
  localparam int HALF_W = ADDR_W - 1;

  logic [HALF_W-1:0] tap_q [2];
  logic              vld_q [2];
  logic              split_q;

  logic              load;
  logic              split_done;
  logic              other;
  logic              byp;
  logic              eff_vld;
  logic [HALF_W-1:0] eff_tap;
  logic              at_end;
  logic [ADDR_W-1:0] nxt;

  assign load       = done && !done_kind[1];
  assign split_done = done && done_kind[1];
  assign step       = sclk_en && !conv_busy;
  assign other      = ~ptr[ADDR_W-1];
  assign byp        = split_done && (done_half == other);
  assign eff_vld    = vld_q[other] || byp;
  assign eff_tap    = byp ? done_tap[HALF_W-1:0] : tap_q[other];
  assign at_end     = split_q && (&ptr[HALF_W-1:0]);
  assign nxt        = at_end ? {other, (eff_vld ? eff_tap : {HALF_W{1'b0}})}
                             : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      flag     <= 1'b0;
      out_mode <= 1'b1;
      split_q  <= 1'b0;
      for (int h = 0; h < 2; h++) begin
        tap_q[h] <= '0;
        vld_q[h] <= 1'b0;
      end
    end else if (load) begin
      ptr      <= done_tap;
      flag     <= done_tap[ADDR_W-1];
      out_mode <= ~done_kind[0];
      split_q  <= 1'b0;
      for (int h = 0; h < 2; h++) vld_q[h] <= 1'b0;
    end else begin
      if (split_done) begin
        tap_q[done_half] <= done_tap[HALF_W-1:0];
        vld_q[done_half] <= 1'b1;
        split_q          <= 1'b1;
      end
      if (step) begin
        ptr  <= nxt;
        flag <= nxt[ADDR_W-1];
        if (at_end) vld_q[other] <= 1'b0;
      end
    end
  end

  // R3: every accepted tick moves the pointer
  a_r3_pointer_moves: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (ptr != $past(ptr)));

  // R11: pointer frozen while a conventional transfer runs
  a_r11_frozen_in_transfer: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && !load) |=> $stable(ptr));

  // R6: the flag flips on the last tick of a half in split mode
  a_r6_flag_toggles_on_hop: assert property (@(posedge clk) disable iff (rst)
    (step && !load && split_q && (&ptr[HALF_W-1:0])) |=> (flag != $past(flag)));

  // R5: a split transfer keeps the direction
  a_r5_split_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    split_done |=> $stable(out_mode));
endmodule

// File: rtl/serial_reg_ctrl.sv
module serial_reg_ctrl #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_en,
  input  logic              ser_en,
  input  logic [DATA_W-1:0] ser_din,
  output logic [DATA_W-1:0] ser_dout,
  output logic              ser_out_mode,
  output logic              half_flag,
  input  logic              xfer_req,
  input  logic [1:0]        xfer_kind,
  input  logic [ADDR_W-1:0] xfer_tap,
  output logic              xfer_ready,
  output logic              xfer_err,
  output logic [ADDR_W-1:0] row_addr,
  output logic              row_rd,
  input  logic [DATA_W-1:0] row_in,
  output logic [DATA_W-1:0] row_out,
  output logic [ADDR_W-1:0] row_out_addr,
  output logic              row_out_we
);
  logic [ADDR_W-1:0] a_addr;
  logic              a_we;
  logic              a_re;
  logic              done;
  logic [1:0]        done_kind;
  logic [ADDR_W-1:0] done_tap;
  logic              done_half;
  logic              conv_busy;
  logic [ADDR_W-1:0] ptr;
  logic              step;
  logic              b_re;
  logic              b_we;

  sar_xfer #(.ADDR_W(ADDR_W)) u_xfer (
    .clk          (clk),
    .rst          (rst),
    .req          (xfer_req),
    .kind         (xfer_kind),
    .tap          (xfer_tap),
    .act_half     (ptr[ADDR_W-1]),
    .ready        (xfer_ready),
    .err          (xfer_err),
    .row_addr     (row_addr),
    .row_rd       (row_rd),
    .row_out_addr (row_out_addr),
    .row_out_we   (row_out_we),
    .a_addr       (a_addr),
    .a_we         (a_we),
    .a_re         (a_re),
    .done         (done),
    .done_kind    (done_kind),
    .done_tap     (done_tap),
    .done_half    (done_half),
    .conv_busy    (conv_busy)
  );

  sar_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .sclk_en   (sclk_en),
    .conv_busy (conv_busy),
    .done      (done),
    .done_kind (done_kind),
    .done_tap  (done_tap),
    .done_half (done_half),
    .ptr       (ptr),
    .step      (step),
    .flag      (half_flag),
    .out_mode  (ser_out_mode)
  );

  assign b_re = step && ser_en && ser_out_mode;
  assign b_we = step && ser_en && !ser_out_mode;

  sar_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .a_we    (a_we),
    .a_re    (a_re),
    .a_addr  (a_addr),
    .a_wdata (row_in),
    .a_rdata (row_out),
    .b_we    (b_we),
    .b_re    (b_re),
    .b_addr  (ptr),
    .b_wdata (ser_din),
    .b_rdata (ser_dout)
  );
endmodule

// File: tb/test_serial_reg_ctrl.sv
module test_serial_reg_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_en = 1'b0;
  logic       ser_en = 1'b1;
  logic [7:0] ser_din = '0;
  logic [7:0] ser_dout;
  logic       ser_out_mode;
  logic       half_flag;
  logic       xfer_req = 1'b0;
  logic [1:0] xfer_kind = 2'b00;
  logic [8:0] xfer_tap = '0;
  logic       xfer_ready;
  logic       xfer_err;
  logic [8:0] row_addr;
  logic       row_rd;
  logic [7:0] row_in;
  logic [7:0] row_out;
  logic [8:0] row_out_addr;
  logic       row_out_we;

  logic [7:0] row_img [512];
  logic [7:0] model   [512];
  logic [7:0] wb_img  [512];

  int n_chk = 0;
  int n_fail = 0;
  int n_rd = 0, n_wr = 0, n_err = 0;
  int min_rd = 9999, min_wr = 9999;
  bit finished = 0;

  always #4 clk = ~clk;

  assign row_in = row_img[row_addr];

  serial_reg_ctrl i_serial_reg_ctrl (
    .clk(clk), .rst(rst), .sclk_en(sclk_en), .ser_en(ser_en),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_out_mode(ser_out_mode),
    .half_flag(half_flag), .xfer_req(xfer_req), .xfer_kind(xfer_kind),
    .xfer_tap(xfer_tap), .xfer_ready(xfer_ready), .xfer_err(xfer_err),
    .row_addr(row_addr), .row_rd(row_rd), .row_in(row_in),
    .row_out(row_out), .row_out_addr(row_out_addr), .row_out_we(row_out_we)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (row_rd) begin
        n_rd++;
        if (int'(row_addr) < min_rd) min_rd = int'(row_addr);
      end
      if (row_out_we) begin
        n_wr++;
        wb_img[row_out_addr] = row_out;
        if (int'(row_out_addr) < min_wr) min_wr = int'(row_out_addr);
      end
      if (xfer_err) n_err++;
    end
  end

  function automatic logic [7:0] pat(input int s, input int i);
    int v;
    v = i * 37 + s * 53 + (i / 256) * 7;
    return v[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_row(input int s);
    for (int i = 0; i < 512; i++) row_img[i] = pat(s, i);
  endtask

  task automatic clear_mon();
    n_rd = 0; n_wr = 0; min_rd = 9999; min_wr = 9999;
  endtask

  task automatic xfer_start(input logic [1:0] k, input logic [8:0] t);
    @(negedge clk);
    xfer_req = 1'b1; xfer_kind = k; xfer_tap = t;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic xfer_wait();
    int guard = 0;
    while (!xfer_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "R12 transfer completes", guard, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sclk(input logic en, input logic [7:0] din);
    @(negedge clk);
    sclk_en = 1'b1; ser_en = en; ser_din = din;
    @(negedge clk);
    sclk_en = 1'b0; ser_en = 1'b1;
  endtask

  task automatic t_reset();
    chk(half_flag == 1'b0, "R1 flag", half_flag, 0);
    chk(ser_out_mode == 1'b1, "R1 mode", ser_out_mode, 1);
    chk(xfer_ready == 1'b1, "R1 ready", xfer_ready, 1);
    chk(xfer_err == 1'b0, "R1 err", xfer_err, 0);
  endtask

  task automatic t_early_split();
    clear_mon();
    n_err = 0;
    @(negedge clk);
    xfer_req = 1'b1; xfer_kind = 2'b10; xfer_tap = 9'd3;
    @(negedge clk);
    xfer_req = 1'b0;
    chk(xfer_err == 1'b1, "R10 err pulse", xfer_err, 1);
    chk(xfer_ready == 1'b1, "R10 stays idle", xfer_ready, 1);
    repeat (5) @(negedge clk);
    chk(n_err == 1, "R10 one-cycle pulse", n_err, 1);
    chk(n_rd == 0 && n_wr == 0, "R10 no row words", n_rd + n_wr, 0);
  endtask

  task automatic t_conv_read();
    clear_mon();
    fill_row(1);
    xfer_start(2'b00, 9'd500);
    chk(xfer_ready == 1'b0, "R12 ready low while busy", xfer_ready, 0);
    xfer_wait();
    for (int i = 0; i < 512; i++) model[i] = row_img[i];
    chk(n_rd == 512, "R12 row read count", n_rd, 512);
    chk(min_rd == 0, "R2 row read start", min_rd, 0);
    chk(ser_out_mode == 1'b1, "R2 output mode", ser_out_mode, 1);
    chk(half_flag == 1'b1, "R6 flag upper after tap 500", half_flag, 1);
    for (int k = 0; k < 20; k++) begin
      sclk(1'b1, 8'h00);
      chk(ser_dout == model[(500 + k) % 512], "R2 serial word", ser_dout,
          model[(500 + k) % 512]);
    end
    chk(half_flag == 1'b0, "R6 flag lower after wrap", half_flag, 0);
  endtask

  task automatic t_ser_disabled();
    logic [7:0] prev;
    prev = ser_dout;
    sclk(1'b0, 8'h00);
    chk(ser_dout == prev, "R3 output held", ser_dout, prev);
    sclk(1'b1, 8'h00);
    chk(ser_dout == model[9], "R3 pointer advanced", ser_dout, model[9]);
  endtask

  task automatic t_read_after_read();
    logic [7:0] prev;
    prev = ser_dout;
    fill_row(2);
    xfer_start(2'b00, 9'd100);
    for (int k = 0; k < 3; k++) begin
      sclk(1'b1, 8'h00);
      chk(ser_dout == prev, "R11 old word held", ser_dout, prev);
    end
    chk(xfer_ready == 1'b0, "R12 busy mid transfer", xfer_ready, 0);
    xfer_wait();
    for (int i = 0; i < 512; i++) model[i] = row_img[i];
    sclk(1'b1, 8'h00);
    chk(ser_dout == model[100], "R11 new word at tap", ser_dout, model[100]);
    sclk(1'b1, 8'h00);
    chk(ser_dout == model[101], "R11 ticks ignored during transfer", ser_dout, model[101]);
  endtask

  task automatic t_split();
    int bad;
    clear_mon();
    fill_row(3);
    xfer_wait();
    xfer_start(2'b10, 9'h0F0);
    xfer_wait();
    for (int i = 256; i < 512; i++) model[i] = row_img[i];
    chk(n_rd == 256, "R8 split load count", n_rd, 256);
    chk(min_rd == 256, "R8 split loads upper only", min_rd, 256);
    chk(ser_out_mode == 1'b1, "R5 split read keeps mode", ser_out_mode, 1);
    bad = 0;
    for (int k = 102; k < 256; k++) begin
      sclk(1'b1, 8'h00);
      if (ser_dout != pat(2, k)) bad++;
    end
    chk(bad == 0, "R8 active half unchanged", bad, 0);
    chk(half_flag == 1'b1, "R6 flag toggles at 255", half_flag, 1);
    sclk(1'b1, 8'h00);
    chk(ser_dout == model[9'h1F0], "R7 hop to stored tap", ser_dout, model[9'h1F0]);
    bad = 0;
    for (int k = 9'h1F1; k < 512; k++) begin
      sclk(1'b1, 8'h00);
      if (ser_dout != model[k]) bad++;
    end
    chk(bad == 0, "R7 upper half run", bad, 0);
    chk(half_flag == 1'b0, "R6 flag toggles at 511", half_flag, 0);
    sclk(1'b1, 8'h00);
    chk(ser_dout == model[0], "R9 no tap enters at 0", ser_dout, model[0]);
    clear_mon();
    xfer_start(2'b11, 9'h0A0);
    xfer_wait();
    chk(n_wr == 256, "R8 split unload count", n_wr, 256);
    chk(min_wr == 256, "R8 split unloads upper only", min_wr, 256);
    bad = 0;
    for (int i = 256; i < 512; i++) if (wb_img[i] != model[i]) bad++;
    chk(bad == 0, "R8 split unload data", bad, 0);
    chk(ser_out_mode == 1'b1, "R5 split write keeps mode", ser_out_mode, 1);
    for (int k = 1; k < 256; k++) sclk(1'b1, 8'h00);
    chk(ser_dout == model[255], "R7 lower run end", ser_dout, model[255]);
    sclk(1'b1, 8'h00);
    chk(ser_dout == model[9'h1A0], "R7 hop to top-bit-ignored tap", ser_dout, model[9'h1A0]);
    chk(half_flag == 1'b1, "R6 flag upper", half_flag, 1);
  endtask

  task automatic t_conv_write();
    int bad;
    clear_mon();
    xfer_start(2'b01, 9'd5);
    xfer_wait();
    chk(n_wr == 512, "R4 row image count", n_wr, 512);
    bad = 0;
    for (int i = 0; i < 512; i++) if (wb_img[i] != model[i]) bad++;
    chk(bad == 0, "R4 row image data", bad, 0);
    chk(ser_out_mode == 1'b0, "R4 input mode", ser_out_mode, 0);
    chk(half_flag == 1'b0, "R6 flag lower after tap 5", half_flag, 0);
    for (int k = 0; k < 5; k++) begin
      sclk(1'b1, 8'hC0 + 8'(k));
      model[5 + k] = 8'hC0 + 8'(k);
    end
    sclk(1'b0, 8'hEE);
    clear_mon();
    xfer_start(2'b01, 9'd0);
    xfer_wait();
    bad = 0;
    for (int k = 0; k < 5; k++) if (wb_img[5 + k] != model[5 + k]) bad++;
    chk(bad == 0, "R4 serial words stored", bad, 0);
    chk(wb_img[10] == model[10], "R3 disabled tick stores nothing", wb_img[10], model[10]);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      row_img[i] = '0; wb_img[i] = '0; model[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_early_split();
    t_conv_read();
    t_ser_disabled();
    t_read_after_read();
    t_split();
    t_conv_write();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule